// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a general-purpose I/O bank of up to 64 pins, held internally as a low word (pins 0 to 31) and a high word (pins 32 and up). Each pin has a direction bit, a drive value and a synchronized input level. Each pin can also raise an edge interrupt. A polarity bit picks which single edge is watched. A sticky status bit records the event. An enable mask gates the event onto the interrupt line, and a wake mask gates it onto the wake line.

Software reaches the bank through a flat register port. The port has a window select (data or interrupt), a word index, a write strobe and a read return that is combinational. To catch both edges, software flips a pin's polarity after each event. Because of this, the status bit must hold an edge that arrives while the previous one is being cleared.

Internally, a two-stage synchronizer feeds both the input-value register and the edge detector. A decoder turns the window and word index into a register identity plus a half-select. The top module applies writes and forms the read data. Pins from the pin-count parameter up to 63 do not exist: they read as zero and ignore writes.

Top module: `gpio_edge_bank`

## Requirements
- R1: Reset clears every register, so all pins start as inputs with zero drive, interrupts disabled and rising polarity. After reset `pad_oe`, `pad_out`, `irq_o` and `wake_o` are all 0.
- R2: In the data window, word index 0 holds direction bits for pins 0–31 and index 1 holds them for pins 32 and up. A 1 makes the pin drive `pad_out`. Indices 6 and 7 hold the drive values for the same two halves. Writes appear on `pad_oe` and `pad_out` in the cycle after the write, and they read back as written.
- R3: In the data window, word indices 4 and 5 return the synchronized pad level of each pin whatever its direction. A pad change is visible there two clock edges after it is applied. Writes to these indices are ignored.
- R4: In the interrupt window, word indices 2 and 3 hold polarity (0 = rising, 1 = falling). A status bit is set only by a transition in the selected direction, three clock edges after the pad changes. A transition in the other direction leaves it unchanged.
- R5: In the interrupt window, word indices 4 and 5 hold the status bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. With no edge and no clearing write, a set bit holds.
- R6: When an edge and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R7: In the interrupt window, word indices 0 and 1 hold the enable mask. `irq_o` is 1 exactly when some status bit and its enable bit are both 1. A disabled pin still records status but does not raise `irq_o`.
- R8: In the interrupt window, word indices 6 and 7 hold the wake mask. `wake_o` is 1 exactly when some status bit and its wake bit are both 1.
- R9: Register bits at or above the pin count read as 0 and ignore writes. Data-window indices 2 and 3 are unmapped: they read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PINS | Raw pad levels |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = data window, 1 = interrupt window |
| bus_addr | input | 3 | Word index within the window (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not selected |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin drive value |
| irq_o | output | 1 | Combined enabled interrupt |
| wake_o | output | 1 | Combined wake request |

## Verification
A corrupted status bit shows up on `irq_o` or `wake_o` in the same cycle, provided its enable or wake bit is set, and it shows in the status readback at once. A stale previous-sample flop creates or loses an event. That error surfaces three edges after the pad change, so the bench samples status exactly at that point. The edge-versus-clear collision is timed so that the clearing write lands on the very edge where the detector fires. A wrong half-select or lane mask shows up as a mismatch in the first readback, or on the pad vectors one cycle after the write.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_OE,
        REG_IN,
        REG_OUT,
        REG_IEN,
        REG_POL,
        REG_STAT,
        REG_WAKE
    } gpio_reg_e;

    // Window bit plus 8-byte slot select the register; word LSB selects the half.
    function automatic gpio_reg_e decode_reg(input logic win, input logic [1:0] slot);
        gpio_reg_e id;
        unique case ({win, slot})
            3'b000:  id = REG_OE;
            3'b001:  id = REG_NONE;
            3'b010:  id = REG_IN;
            3'b011:  id = REG_OUT;
            3'b100:  id = REG_IEN;
            3'b101:  id = REG_POL;
            3'b110:  id = REG_STAT;
            3'b111:  id = REG_WAKE;
            default: id = REG_NONE;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_edge_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_win,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output gpio_reg_e             reg_id,
    output logic                  hi_half,
    output logic                  wr_hit,
    output logic [2*WORD_W-1:0]   wr_vec,
    output logic [2*WORD_W-1:0]   wr_lane
);
    localparam int SPAN = 2 * WORD_W;

    always_comb begin
        reg_id  = decode_reg(bus_win, bus_addr[2:1]);
        hi_half = bus_addr[0];
        wr_hit  = bus_sel && bus_wr;
        if (hi_half) begin
            wr_vec  = {bus_wdata, {WORD_W{1'b0}}};
            wr_lane = {{WORD_W{1'b1}}, {WORD_W{1'b0}}};
        end else begin
            wr_vec  = SPAN'(bus_wdata);
            wr_lane = SPAN'({WORD_W{1'b1}});
        end
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] clr,
    input  logic [NUM_PINS-1:0] ien,
    input  logic [NUM_PINS-1:0] wen,
    output logic [NUM_PINS-1:0] stat,
    output logic                irq,
    output logic                wake
);
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] stat_q;
    logic [NUM_PINS-1:0] hit;

    // One detector per pin; polarity picks the single watched edge.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            if (pol[p]) hit[p] = prev_q[p] && !lvl[p];
            else        hit[p] = !prev_q[p] && lvl[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~clr) | hit;   // a new edge outranks the clear
        end
    end

    assign stat = stat_q;
    assign irq  = |(stat_q & ien);
    assign wake = |(stat_q & wen);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 36,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_win,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic                irq_o,
    output logic                wake_o
);
    localparam int SPAN = 2 * WORD_W;

    gpio_reg_e         reg_id;
    logic              hi_half;
    logic              wr_hit;
    logic [SPAN-1:0]   wr_vec;
    logic [SPAN-1:0]   wr_lane;

    logic [NUM_PINS-1:0] oe_q,  oe_d;
    logic [NUM_PINS-1:0] out_q, out_d;
    logic [NUM_PINS-1:0] ien_q, ien_d;
    logic [NUM_PINS-1:0] pol_q, pol_d;
    logic [NUM_PINS-1:0] wen_q, wen_d;
    logic [NUM_PINS-1:0] clr;
    logic [NUM_PINS-1:0] lvl_sync;
    logic [NUM_PINS-1:0] stat_q;
    logic [SPAN-1:0]     rd_full;

    gpio_bus_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reg_id    (reg_id),
        .hi_half   (hi_half),
        .wr_hit    (wr_hit),
        .wr_vec    (wr_vec),
        .wr_lane   (wr_lane)
    );

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl_sync)
    );

    gpio_edge_irq #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_sync),
        .pol   (pol_q),
        .clr   (clr),
        .ien   (ien_q),
        .wen   (wen_q),
        .stat  (stat_q),
        .irq   (irq_o),
        .wake  (wake_o)
    );

    function automatic logic [NUM_PINS-1:0] merge(input logic [NUM_PINS-1:0] cur,
                                                  input logic [SPAN-1:0] vec,
                                                  input logic [SPAN-1:0] lane);
        return NUM_PINS'((SPAN'(cur) & ~lane) | (vec & lane));
    endfunction

    // Next-state of the writable registers.
    always_comb begin
        oe_d  = oe_q;
        out_d = out_q;
        ien_d = ien_q;
        pol_d = pol_q;
        wen_d = wen_q;
        clr   = '0;
        if (wr_hit) begin
            unique case (reg_id)
                REG_OE:   oe_d  = merge(oe_q,  wr_vec, wr_lane);
                REG_OUT:  out_d = merge(out_q, wr_vec, wr_lane);
                REG_IEN:  ien_d = merge(ien_q, wr_vec, wr_lane);
                REG_POL:  pol_d = merge(pol_q, wr_vec, wr_lane);
                REG_WAKE: wen_d = merge(wen_q, wr_vec, wr_lane);
                REG_STAT: clr   = NUM_PINS'(wr_vec & wr_lane);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= '0;
            out_q <= '0;
            ien_q <= '0;
            pol_q <= '0;
            wen_q <= '0;
        end else begin
            oe_q  <= oe_d;
            out_q <= out_d;
            ien_q <= ien_d;
            pol_q <= pol_d;
            wen_q <= wen_d;
        end
    end

    // Read return, zero-padded above the pin count.
    always_comb begin
        unique case (reg_id)
            REG_OE:   rd_full = SPAN'(oe_q);
            REG_IN:   rd_full = SPAN'(lvl_sync);
            REG_OUT:  rd_full = SPAN'(out_q);
            REG_IEN:  rd_full = SPAN'(ien_q);
            REG_POL:  rd_full = SPAN'(pol_q);
            REG_STAT: rd_full = SPAN'(stat_q);
            REG_WAKE: rd_full = SPAN'(wen_q);
            default:  rd_full = '0;
        endcase
        if (!bus_sel)     bus_rdata = '0;
        else if (hi_half) bus_rdata = rd_full[WORD_W +: WORD_W];
        else              bus_rdata = rd_full[0 +: WORD_W];
    end

    assign pad_oe  = oe_q;
    assign pad_out = out_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
    parameter int NUM_PINS = 36,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic                bus_win,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                irq_o,
    input logic                wake_o,
    input logic [NUM_PINS-1:0] stat_q,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] lvl
);
    logic oe_wr;
    logic stat_wr;
    assign oe_wr   = bus_sel && bus_wr && !bus_win && (bus_addr[2:1] == 2'b00);
    assign stat_wr = bus_sel && bus_wr &&  bus_win && (bus_addr[2:1] == 2'b10);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && !irq_o && !wake_o));

    a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(oe_wr) |-> $stable(pad_oe));

    a_r4_status_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) != '0) |-> ($past(lvl) != $past(lvl, 2)));

    a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_wr) |-> (($past(stat_q) & ~stat_q) == '0));

    a_r7_irq_needs_enabled_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != '0 && ien_q != '0));

    a_r8_wake_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (stat_q != '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_win  (bus_win),
    .bus_addr (bus_addr),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .stat_q   (stat_q),
    .ien_q    (ien_q),
    .lvl      (lvl_sync)
);

// File: tb/test_gpio_edge_bank.sv
module test_gpio_edge_bank;
    localparam int NP = 36;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_win = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic          irq_o;
    logic          wake_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] got;

    always #4 clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(NP)) i_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq_o(irq_o), .wake_o(wake_o)
    );

    // {window, word index, write data, expected readback}
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 3'd0, 32'hA5A5F00F, 32'hA5A5F00F},
        {1'b0, 3'd1, 32'hFFFFFFFF, 32'h0000000F},
        {1'b0, 3'd6, 32'h12345678, 32'h12345678},
        {1'b0, 3'd7, 32'h000000F3, 32'h00000003},
        {1'b0, 3'd2, 32'hFFFFFFFF, 32'h00000000},
        {1'b0, 3'd4, 32'hFFFFFFFF, 32'h00000000},
        {1'b1, 3'd0, 32'h0F0F0F0F, 32'h0F0F0F0F},
        {1'b1, 3'd2, 32'h00000001, 32'h00000001},
        {1'b1, 3'd3, 32'hFFFFFFFF, 32'h0000000F},
        {1'b1, 3'd6, 32'h80000000, 32'h80000000},
        {1'b1, 3'd7, 32'h00000000, 32'h00000000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_win = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic w, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_win = w; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        w;
        logic [2:0]  a;
        logic [31:0] d, e;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);
        chk("R1 pad_out", 64'(pad_out), 64'd0);
        chk("R1 irq_o", 64'(irq_o), 64'd0);
        chk("R1 wake_o", 64'(wake_o), 64'd0);
        rst_n = 1'b1;
        rd(1'b1, 3'd2, got); chk("R1 polarity", 64'(got), 64'd0);
        rd(1'b1, 3'd0, got); chk("R1 enable", 64'(got), 64'd0);

        // R2 R3 R9: write/readback table
        for (int i = 0; i < NV; i++) begin
            {w, a, d, e} = VEC[i];
            wr(w, a, d);
            rd(w, a, got);
            chk($sformatf("R2 R3 R9 table entry %0d", i), 64'(got), 64'(e));
        end
        chk("R2 pad_oe", 64'(pad_oe), 64'h0F_A5A5F00F);
        chk("R2 pad_out", 64'(pad_out), 64'h03_12345678);
        chk("R7 no status no irq", 64'(irq_o), 64'd0);

        // clear interrupt setup
        wr(1'b1, 3'd0, 32'h0); wr(1'b1, 3'd1, 32'h0);
        wr(1'b1, 3'd2, 32'h0); wr(1'b1, 3'd3, 32'h0);
        wr(1'b1, 3'd6, 32'h0); wr(1'b1, 3'd7, 32'h0);

        // R3: input level regardless of direction (pins 0 and 35 are outputs)
        @(negedge clk); pad_in = 36'h9_0000_0001;
        repeat (3) @(negedge clk);
        rd(1'b0, 3'd4, got); chk("R3 input low half", 64'(got), 64'h1);
        rd(1'b0, 3'd5, got); chk("R3 input high half", 64'(got), 64'h9);
        rd(1'b1, 3'd4, got); chk("R4 rising status low", 64'(got), 64'h1);
        rd(1'b1, 3'd5, got); chk("R4 rising status high", 64'(got), 64'h9);
        chk("R7 disabled pins no irq", 64'(irq_o), 64'd0);
        chk("R8 no wake mask", 64'(wake_o), 64'd0);

        // R5: write-one-to-clear
        wr(1'b1, 3'd5, 32'h1);
        rd(1'b1, 3'd5, got); chk("R5 clear pin 32 only", 64'(got), 64'h8);
        wr(1'b1, 3'd4, 32'h0);
        rd(1'b1, 3'd4, got); chk("R5 zero write keeps", 64'(got), 64'h1);
        wr(1'b1, 3'd4, 32'h1);
        rd(1'b1, 3'd4, got); chk("R5 clear pin 0", 64'(got), 64'h0);

        // R7: enable gating
        wr(1'b1, 3'd1, 32'h8);
        chk("R7 enabled status raises irq", 64'(irq_o), 64'd1);
        wr(1'b1, 3'd5, 32'h8);
        chk("R7 cleared status drops irq", 64'(irq_o), 64'd0);
        wr(1'b1, 3'd1, 32'h0);

        // R4: falling polarity on pin 1
        wr(1'b1, 3'd2, 32'h2);
        @(negedge clk); pad_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(1'b1, 3'd4, got); chk("R4 rise ignored on falling pin", 64'(got), 64'h0);
        @(negedge clk); pad_in[1:0] = 2'b00;
        repeat (4) @(negedge clk);
        rd(1'b1, 3'd4, got); chk("R4 fall caught, fall ignored on rising pin", 64'(got), 64'h2);

        // R8: wake mask
        wr(1'b1, 3'd6, 32'h2);
        chk("R8 wake raised", 64'(wake_o), 64'd1);
        chk("R7 wake does not raise irq", 64'(irq_o), 64'd0);
        wr(1'b1, 3'd4, 32'h2);
        chk("R8 wake cleared", 64'(wake_o), 64'd0);
        wr(1'b1, 3'd6, 32'h0);

        // R6: edge and clear on the same clock edge
        @(negedge clk); pad_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_win = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(1'b1, 3'd4, got); chk("R6 edge beats clear", 64'(got), 64'h4);
        wr(1'b1, 3'd4, 32'h4);
        rd(1'b1, 3'd4, got); chk("R5 clear without edge", 64'(got), 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule